// File: doc/BRIEF.md
# Manchester II Word Transmitter with Back-to-Back Queuing

This block turns a 16-bit value and a sync-type flag into one serial word of twenty bit periods. The word is bi-phase (Manchester II) encoded at one bit per `CLK_PER_BIT` clocks, which is 1 us with a 12 MHz clock. Each word has three parts:

- a three-period sync whose polarity marks it as a command/status word or a data word;
- the sixteen data bits, most significant first;
- an odd-parity bit.

The word leaves on the positive and negative lines of one of two buses. The bus is chosen per word when the word is written. Each bus can be silenced on its own without changing the timing.

The block has two storage stages, a pending-word register and the active shift pattern. A word written while the current one is still being sent moves into the shift pattern at the exact clock the current parity bit ends, so a multi-word message leaves the wire with no gap. A ready flag tells the writer when such a write is timely. It is high while the transmitter is idle. During a word it is high only from 3.5 to 18.5 bit periods after the word starts.

Top module: `manchester_word_tx`

## Requirements
- R1: While reset is asserted and after its release, all four line outputs are low and `ready` is high.
- R2: A word spans 40 half-bit slots of `CLK_PER_BIT/2` clocks each. A command sync (`wr_cmd_sync`=1) is high for slots 0-2 and low for slots 3-5. A data sync (`wr_cmd_sync`=0) is the reverse. Data bit 15 takes slots 6-7 and bit 0 takes slots 36-37. A one is sent high then low, a zero low then high.
- R3: Slots 38-39 carry the parity bit: 1 when the data holds an even number of ones, so that data plus parity is odd.
- R4: A write accepted while idle puts slot 0 on the line on the second clock edge after the write is sampled.
- R5: `wr_bus_b`=0 sends on bus A and 1 sends on bus B, as sampled with the write. The other bus stays low on both lines, and the active bus drives `p` equal to the line level with `n` its complement.
- R6: While `dis_a` (`dis_b`) is high, both lines of bus A (B) stay low. The word timing and `ready` are unchanged.
- R7: During a word, `ready` is high from clock 42 through clock 221 of the word (clock 0 is the first slot-0 clock) and low otherwise. This is 3.5 and 18.5 bit periods at 12 clocks per bit.
- R8: A word written during a word starts slot 0 on the clock right after the last parity clock, with no idle clock between.
- R9: A second write before the pending word has started replaces it. Only the last written value is sent.
- R10: After the parity bit, with nothing pending, the outputs return to all low and `ready` returns high on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-clock write strobe for a new word |
| wr_data | input | 16 | Word payload |
| wr_cmd_sync | input | 1 | 1 = command/status sync, 0 = data sync |
| wr_bus_b | input | 1 | 0 = bus A, 1 = bus B |
| dis_a | input | 1 | Silence bus A lines |
| dis_b | input | 1 | Silence bus B lines |
| ready | output | 1 | Timely window for the next write |
| bus_a_p | output | 1 | Bus A positive line |
| bus_a_n | output | 1 | Bus A negative line |
| bus_b_p | output | 1 | Bus B positive line |
| bus_b_n | output | 1 | Bus B negative line |

## Verification
A corrupt shift pattern or a bad parity computation shows as a wrong line level within six clocks of the faulty half-slot. A slip in the clock or half-bit counters moves every later transition and the `ready` edges, so it appears inside one word. A stale pending flag shows either as a missing contiguous word at clock 240 or as a spurious word after an idle period. A wrong captured bus shows at once as activity on the unselected lines.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  localparam int DATA_W    = 16;
  localparam int SYNC_BITS = 3;
  localparam int WORD_BITS = SYNC_BITS + DATA_W + 1;
  localparam int SLOTS     = 2 * WORD_BITS;

  typedef enum logic {
    SYNC_DATA = 1'b0,
    SYNC_CMD  = 1'b1
  } sync_e;

  typedef struct packed {
    sync_e             sync;
    logic              bus_sel;
    logic [DATA_W-1:0] data;
  } txw_t;

  // parity bit that makes data plus parity carry an odd count of ones
  function automatic logic odd_par(input logic [DATA_W-1:0] d);
    return ~(^d);
  endfunction

  // line level per half-bit slot, slot 0 at the MSB
  function automatic logic [SLOTS-1:0] halfslots(input txw_t w);
    logic [SLOTS-1:0] p;
    logic             pb;
    p = '0;
    for (int s = 0; s < 2*SYNC_BITS; s++) begin
      if (w.sync == SYNC_CMD) p[SLOTS-1-s] = (s < SYNC_BITS);
      else                    p[SLOTS-1-s] = (s >= SYNC_BITS);
    end
    for (int i = 0; i < DATA_W; i++) begin
      p[SLOTS-1-2*SYNC_BITS-2*i]   =  w.data[DATA_W-1-i];
      p[SLOTS-2-2*SYNC_BITS-2*i]   = ~w.data[DATA_W-1-i];
    end
    pb   = odd_par(w.data);
    p[1] = pb;
    p[0] = ~pb;
    return p;
  endfunction

endpackage

// File: rtl/mtx_hold.sv
module mtx_hold
  import mtx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  txw_t wr_word,
  input  logic take,
  output logic vld,
  output txw_t word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      word <= '0;
    end else if (wr_en) begin
      vld  <= 1'b1;
      word <= wr_word;
    end else if (take) begin
      vld  <= 1'b0;
    end
  end

endmodule

// File: rtl/mtx_timer.sv
module mtx_timer
  import mtx_pkg::*;
#(
  parameter int CLK_PER_BIT = 12,
  parameter int ON_HALVES   = 7,
  parameter int OFF_HALVES  = 37
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic half_end,
  output logic last_clk,
  output logic ready_win
);

  localparam int HALF      = CLK_PER_BIT / 2;
  localparam int WORD_CLKS = WORD_BITS * CLK_PER_BIT;
  localparam int RDY_ON    = (ON_HALVES * CLK_PER_BIT) / 2;
  localparam int RDY_OFF   = (OFF_HALVES * CLK_PER_BIT) / 2;
  localparam int TW        = $clog2(WORD_CLKS);
  localparam int HW        = $clog2(HALF + 1);

  logic [TW-1:0] tick;
  logic [HW-1:0] half;

  assign half_end  = busy && (half == HW'(HALF - 1));
  assign last_clk  = busy && (tick == TW'(WORD_CLKS - 1));
  assign ready_win = (tick >= TW'(RDY_ON)) && (tick < TW'(RDY_OFF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tick <= '0;
      half <= '0;
    end else if (start) begin
      busy <= 1'b1;
      tick <= '0;
      half <= '0;
    end else if (busy) begin
      busy <= !last_clk;
      tick <= last_clk ? '0 : tick + 1'b1;
      half <= half_end ? '0 : half + 1'b1;
    end
  end

endmodule

// File: rtl/mtx_shifter.sv
module mtx_shifter
  import mtx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic half_end,
  input  txw_t next_word,
  output logic line_lvl,
  output logic cur_bus
);

  logic [SLOTS-1:0] pat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat     <= '0;
      cur_bus <= 1'b0;
    end else if (start) begin
      pat     <= halfslots(next_word);
      cur_bus <= next_word.bus_sel;
    end else if (half_end) begin
      pat     <= {pat[SLOTS-2:0], 1'b0};
    end
  end

  assign line_lvl = pat[SLOTS-1];

endmodule

// File: rtl/mtx_bus_gate.sv
module mtx_bus_gate #(
  parameter int NUM_BUS = 2,
  localparam int SW     = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic               busy,
  input  logic               lvl,
  input  logic [SW-1:0]      sel,
  input  logic [NUM_BUS-1:0] dis,
  output logic [NUM_BUS-1:0] pos,
  output logic [NUM_BUS-1:0] neg
);

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
    logic act;
    assign act    = busy && (sel == SW'(g)) && !dis[g];
    assign pos[g] = act &  lvl;
    assign neg[g] = act & ~lvl;
  end

endmodule

// File: rtl/manchester_word_tx.sv
module manchester_word_tx
  import mtx_pkg::*;
#(
  parameter int CLK_PER_BIT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        wr_cmd_sync,
  input  logic        wr_bus_b,
  input  logic        dis_a,
  input  logic        dis_b,
  output logic        ready,
  output logic        bus_a_p,
  output logic        bus_a_n,
  output logic        bus_b_p,
  output logic        bus_b_n
);

  // named internal events, also observed by the checker
  logic busy, hold_vld, start, half_end, last_clk, ready_win, line_lvl, cur_bus;
  txw_t wr_word, hold_word;
  logic [1:0] pos, neg;

  assign wr_word = '{sync: sync_e'(wr_cmd_sync), bus_sel: wr_bus_b, data: wr_data};
  assign start   = hold_vld && (!busy || last_clk);

  mtx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .take(start), .vld(hold_vld), .word(hold_word)
  );

  mtx_timer #(.CLK_PER_BIT(CLK_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .half_end(half_end), .last_clk(last_clk), .ready_win(ready_win)
  );

  mtx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .half_end(half_end),
    .next_word(hold_word), .line_lvl(line_lvl), .cur_bus(cur_bus)
  );

  mtx_bus_gate #(.NUM_BUS(2)) u_gate (
    .busy(busy), .lvl(line_lvl), .sel(cur_bus), .dis({dis_b, dis_a}),
    .pos(pos), .neg(neg)
  );

  assign ready   = busy ? ready_win : ~hold_vld;
  assign bus_a_p = pos[0];
  assign bus_a_n = neg[0];
  assign bus_b_p = pos[1];
  assign bus_b_n = neg[1];

endmodule

// File: rtl/mtx_checker.sv
module mtx_checker (
  input logic clk,
  input logic rst_n,
  input logic dis_a,
  input logic dis_b,
  input logic ready,
  input logic bus_a_p,
  input logic bus_a_n,
  input logic bus_b_p,
  input logic bus_b_n,
  input logic busy,
  input logic hold_vld,
  input logic start,
  input logic half_end,
  input logic last_clk,
  input logic line_lvl
);

  p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !half_end && !start) |=> $stable(line_lvl));

  p_one_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !((bus_a_p || bus_a_n) && (bus_b_p || bus_b_n)));

  p_dis_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dis_a |-> !(bus_a_p || bus_a_n));

  p_dis_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dis_b |-> !(bus_b_p || bus_b_n));

  p_start_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

  p_end_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_clk |-> !ready);

  p_contig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_clk && hold_vld) |=> busy);

  p_idle_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !(bus_a_p || bus_a_n || bus_b_p || bus_b_n));

endmodule

bind manchester_word_tx mtx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .dis_a(dis_a), .dis_b(dis_b), .ready(ready),
  .bus_a_p(bus_a_p), .bus_a_n(bus_a_n), .bus_b_p(bus_b_p), .bus_b_n(bus_b_n),
  .busy(busy), .hold_vld(hold_vld), .start(start), .half_end(half_end),
  .last_clk(last_clk), .line_lvl(line_lvl)
);

// File: tb/tb_manchester_word_tx.sv
module tb_manchester_word_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_cmd_sync = 1'b0;
  logic        wr_bus_b = 1'b0;
  logic        dis_a = 1'b0;
  logic        dis_b = 1'b0;
  logic        ready, bus_a_p, bus_a_n, bus_b_p, bus_b_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  manchester_word_tx dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_cmd_sync(wr_cmd_sync), .wr_bus_b(wr_bus_b), .dis_a(dis_a), .dis_b(dis_b),
    .ready(ready), .bus_a_p(bus_a_p), .bus_a_n(bus_a_n),
    .bus_b_p(bus_b_p), .bus_b_n(bus_b_n)
  );

  // expected level for half-slot s, restated from R2/R3
  function automatic logic exp_lvl(input logic cmd, input logic [15:0] d, input int s);
    int  per = s / 2;
    bit  first = (s % 2) == 0;
    logic b;
    if (per < 3) return cmd ? (s < 3) : (s >= 3);
    if (per < 19) b = d[18 - per];
    else          b = ($countones(d) % 2) == 0;
    return first ? b : ~b;
  endfunction

  task automatic chk(input string req, input bit ok, input string detail);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", req, detail);
    end
  endtask

  task automatic check_idle(input string req);
    logic [3:0] act;
    act = {bus_a_p, bus_a_n, bus_b_p, bus_b_n};
    chk(req, act == 4'b0 && ready == 1'b1,
        $sformatf("idle: lines=%b ready=%b expected lines=0000 ready=1", act, ready));
  endtask

  // write from idle; returns at the negedge showing slot 0 (R4)
  task automatic start_idle(input logic [15:0] d, input logic cmd, input logic bb);
    wr_data = d; wr_cmd_sync = cmd; wr_bus_b = bb; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = ~d; wr_cmd_sync = ~cmd; wr_bus_b = ~bb;
    @(negedge clk);
  endtask

  // checks one 240-clock word; optional writes at clocks wk1 / wk2
  task automatic run_word(input string tag, input logic bb, input logic cmd, input logic [15:0] d,
                          input int wk1, input logic [15:0] d1, input logic c1, input logic b1,
                          input int wk2, input logic [15:0] d2, input logic c2, input logic b2);
    int bad_l = 0, bad_r = 0, fk_l = -1, fk_r = -1;
    logic [3:0] fa_l = '0, fe_l = '0;
    logic fa_r = 1'b0, fe_r = 1'b0;
    for (int k = 0; k < 240; k++) begin
      logic lv, ea, eb, er;
      logic [3:0] act, exp4;
      lv   = exp_lvl(cmd, d, k / 6);
      ea   = !bb && !dis_a;
      eb   =  bb && !dis_b;
      exp4 = {ea & lv, ea & ~lv, eb & lv, eb & ~lv};
      act  = {bus_a_p, bus_a_n, bus_b_p, bus_b_n};
      er   = (k >= 42) && (k < 222);
      if (act !== exp4) begin
        if (bad_l == 0) begin fk_l = k; fa_l = act; fe_l = exp4; end
        bad_l++;
      end
      if (ready !== er) begin
        if (bad_r == 0) begin fk_r = k; fa_r = ready; fe_r = er; end
        bad_r++;
      end
      if (k == wk1) begin
        wr_en = 1'b1; wr_data = d1; wr_cmd_sync = c1; wr_bus_b = b1;
      end else if (k == wk2) begin
        wr_en = 1'b1; wr_data = d2; wr_cmd_sync = c2; wr_bus_b = b2;
      end else begin
        wr_en = 1'b0; wr_bus_b = $urandom_range(0, 1); wr_cmd_sync = $urandom_range(0, 1);
        wr_data = 16'($urandom);
      end
      @(negedge clk);
    end
    chk({tag, " R2 R3 R5 R6 R8"}, bad_l == 0,
        $sformatf("lines at clock %0d: %b expected %b (%0d mismatches)", fk_l, fa_l, fe_l, bad_l));
    chk({tag, " R7"}, bad_r == 0,
        $sformatf("ready at clock %0d: %b expected %b", fk_r, fa_r, fe_r));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] cd, nd;
    logic cc, cb, nc, nb;
    void'($urandom(32'h1553));
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    // single words from idle, both sync kinds and both buses
    start_idle(16'h8001, 1'b1, 1'b0);
    run_word("R4 cmd A even", 1'b0, 1'b1, 16'h8001, -1, '0, 1'b0, 1'b0, -1, '0, 1'b0, 1'b0);
    check_idle("R10 after word");
    @(negedge clk);

    // contiguous chain: write at first ready clock, then last ready clock
    start_idle(16'h0007, 1'b0, 1'b1);
    run_word("R8 data B odd", 1'b1, 1'b0, 16'h0007, 42, 16'hFFFF, 1'b1, 1'b0, -1, '0, 1'b0, 1'b0);
    run_word("R8 ones A", 1'b0, 1'b1, 16'hFFFF, 221, 16'h0000, 1'b0, 1'b1, -1, '0, 1'b0, 1'b0);
    // overwrite of a pending word
    run_word("R9 zeros B", 1'b1, 1'b0, 16'h0000, 100, 16'h1234, 1'b1, 1'b0, 150, 16'hBEEF, 1'b0, 1'b1);
    run_word("R9 last write wins", 1'b1, 1'b0, 16'hBEEF, -1, '0, 1'b0, 1'b0, -1, '0, 1'b0, 1'b0);
    check_idle("R10 after chain");

    // disabled buses keep timing
    dis_a = 1'b1;
    start_idle(16'h5A5A, 1'b1, 1'b0);
    run_word("R6 A silenced", 1'b0, 1'b1, 16'h5A5A, 60, 16'hC3C3, 1'b0, 1'b1, -1, '0, 1'b0, 1'b0);
    run_word("R6 B while A off", 1'b1, 1'b0, 16'hC3C3, -1, '0, 1'b0, 1'b0, -1, '0, 1'b0, 1'b0);
    dis_a = 1'b0;
    dis_b = 1'b1;
    start_idle(16'h0F0F, 1'b0, 1'b1);
    run_word("R6 B silenced", 1'b1, 1'b0, 16'h0F0F, -1, '0, 1'b0, 1'b0, -1, '0, 1'b0, 1'b0);
    dis_b = 1'b0;
    check_idle("R10 after disabled word");

    // random chain of contiguous words
    cd = 16'($urandom); cc = $urandom_range(0, 1); cb = $urandom_range(0, 1);
    start_idle(cd, cc, cb);
    for (int i = 0; i < 10; i++) begin
      nd = 16'($urandom); nc = $urandom_range(0, 1); nb = $urandom_range(0, 1);
      if (i < 9)
        run_word("R8 random", cb, cc, cd, $urandom_range(42, 221), nd, nc, nb, -1, '0, 1'b0, 1'b0);
      else
        run_word("R2 random last", cb, cc, cd, -1, '0, 1'b0, 1'b0, -1, '0, 1'b0, 1'b0);
      cd = nd; cc = nc; cb = nb;
    end
    check_idle("R10 after random chain");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule